// File: doc/BRIEF.md
# Serial-Load Code Calibration Table

This block turns a 6-bit raw measurement code into a corrected 6-bit code. It uses a table with one 6-bit entry for each of the 64 possible raw values. The table is written one bit at a time from a slow external pair of lines: a strobe (`cal_clk`) and a data line (`cal_dat`). Both lines are brought into the system clock domain by a synchronizer. A bit is taken in on each rising edge of the strobe that the system clock detects.

The table forms one 384-bit shift chain. The first bit sent lands in the most significant bit of the highest entry, and the last bit sent lands in the least significant bit of entry 0. Reset fills the table with the identity mapping, so turning the correction on before any load still gives the raw code. A separate enable input chooses between the table output and the raw code, and it can be switched at any time. A `loaded` flag rises once a full table's worth of bits has arrived.

Top module: `cal_lut`

## Requirements
- R1: While `rst_n` is low, `cal_code` is 0 and `loaded` is 0.
- R2: When `cal_ena` is 0 at a clock edge, `cal_code` after that edge equals the `raw_code` sampled at that edge.
- R3: When `cal_ena` is 1 at a clock edge, `cal_code` after that edge equals the table entry indexed by the `raw_code` sampled at that edge.
- R4: Each detected rising edge of `cal_clk` shifts the level of `cal_dat` into the table. The `cal_clk` and `cal_dat` lines pass through a two-flop synchronizer, and `cal_dat` must be stable around the edge. The chain runs from entry 0 bit 0, where new bits enter, up to entry 63 bit 5, where bits leave. Each bit moves from bit 5 of entry e into bit 0 of entry e+1. So a full load sends entry 63 first and entry 0 last, each entry most significant bit first.
- R5: Reset sets every entry e to the value e, so with `cal_ena` at 1 and no load done, `cal_code` equals `raw_code`.
- R6: An internal count of received bits goes up by one for each shifted bit and stops at 384.
- R7: `loaded` goes high once the 384th bit since reset has been shifted, and stays high until the next reset.
- R8: Bits received after `loaded` keep shifting, so the table always holds the last 384 bits received.
- R9: A change on `cal_dat` while `cal_clk` is held steady, high or low, does not change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_code | input | 6 | Uncorrected measurement code |
| cal_ena | input | 1 | 1 selects the table output, 0 passes the raw code through |
| cal_clk | input | 1 | Slow serial load strobe, asynchronous to `clk` |
| cal_dat | input | 1 | Serial load data, taken on rising edges of `cal_clk` |
| cal_code | output | 6 | Registered output code |
| loaded | output | 1 | High once a full table has been received |

## Verification
A wrong table bit has no effect at the ports until `cal_ena` is 1 and `raw_code` selects that entry. It then shows in `cal_code` one clock later. For this reason the bench sweeps all 64 codes after every load phase, and does not rely on random probing alone. A shift-order or chain-linkage fault moves whole entries, which shows at the first sweep after a partial load. A miscounted bit total shows as `loaded` rising one bit early or late, and it is checked right after the 383rd and the 384th bit.

// File: rtl/cal_lut.sv
module cal_lut #(
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] raw_code,
  input  logic              cal_ena,
  input  logic              cal_clk,
  input  logic              cal_dat,
  output logic [CODE_W-1:0] cal_code,
  output logic              loaded
);
  localparam int ENTRIES = 1 << CODE_W;
  localparam int CHAIN_W = ENTRIES * CODE_W;
  localparam int CNT_W   = $clog2(CHAIN_W + 1);

  logic [SYNC_STAGES-1:0] clk_sync, dat_sync;
  logic                   clk_prev;
  logic                   shift_now, shift_bit;
  logic [CNT_W-1:0]       bit_cnt;
  logic [CODE_W-1:0]      tbl [ENTRIES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sync <= '0;
      dat_sync <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], cal_clk};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], cal_dat};
      clk_prev <= clk_sync[SYNC_STAGES-1];
    end

  assign shift_now = clk_sync[SYNC_STAGES-1] & ~clk_prev;
  assign shift_bit = dat_sync[SYNC_STAGES-1];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic carry_in;
    if (e == 0) begin : g_head
      assign carry_in = shift_bit;
    end else begin : g_link
      assign carry_in = tbl[e-1][CODE_W-1];
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        tbl[e] <= CODE_W'(e);
      else if (shift_now)
        tbl[e] <= {tbl[e][CODE_W-2:0], carry_in};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      bit_cnt <= '0;
    else if (shift_now && bit_cnt != CNT_W'(CHAIN_W))
      bit_cnt <= bit_cnt + 1'b1;

  assign loaded = (bit_cnt == CNT_W'(CHAIN_W));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cal_code <= '0;
    else
      cal_code <= cal_ena ? tbl[raw_code] : raw_code;
endmodule

module cal_lut_chk #(
  parameter int CODE_W  = 6,
  parameter int CHAIN_W = 384,
  parameter int CNT_W   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] raw_code,
  input logic              cal_ena,
  input logic [CODE_W-1:0] cal_code,
  input logic              loaded,
  input logic [CNT_W-1:0]  bit_cnt
);
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_ena |=> cal_code == $past(raw_code));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(CHAIN_W));

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt != $past(bit_cnt) |-> bit_cnt == $past(bit_cnt) + 1'b1);

  a_r7_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);

  a_r7_loaded_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> $past(bit_cnt) == CNT_W'(CHAIN_W - 1));
endmodule

bind cal_lut cal_lut_chk #(.CODE_W(CODE_W), .CHAIN_W(CHAIN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_code(raw_code), .cal_ena(cal_ena),
  .cal_code(cal_code), .loaded(loaded), .bit_cnt(bit_cnt)
);

// File: tb/test_cal_lut.sv
module test_cal_lut;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] raw_code = '0;
  logic       cal_ena = 1'b0;
  logic       cal_clk = 1'b0;
  logic       cal_dat = 1'b0;
  logic [5:0] cal_code;
  logic       loaded;

  int checks = 0;
  int failures = 0;
  logic [383:0] mdl;

  always #2 clk = ~clk;

  cal_lut i_cal_lut (
    .clk(clk), .rst_n(rst_n), .raw_code(raw_code), .cal_ena(cal_ena),
    .cal_clk(cal_clk), .cal_dat(cal_dat), .cal_code(cal_code), .loaded(loaded)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [383:0] identity_tab();
    logic [383:0] t;
    for (int e = 0; e < 64; e++) t[e*6 +: 6] = 6'(e);
    return t;
  endfunction

  function automatic int expect_code(input int r, input bit ena);
    return ena ? int'(mdl[r*6 +: 6]) : r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cal_clk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cal_code in reset", cal_code, 0);
    chk("R1 loaded in reset", loaded, 0);
    rst_n = 1'b1;
    mdl = identity_tab();
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    cal_dat = b;
    repeat (2) @(negedge clk);
    cal_clk = 1'b1;
    repeat (4) @(negedge clk);
    cal_clk = 1'b0;
    repeat (4) @(negedge clk);
    mdl = {mdl[382:0], b};
  endtask

  task automatic lookup(input int r, input bit ena, input string req);
    @(negedge clk);
    raw_code = 6'(r);
    cal_ena = ena;
    @(negedge clk);
    chk(req, cal_code, expect_code(r, ena));
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 64; r++) lookup(r, 1'b1, req);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7351));
    mdl = identity_tab();
    do_reset();

    sweep("R5 identity before load");
    lookup(0, 1'b0, "R2 bypass low corner");
    lookup(63, 1'b0, "R2 bypass high corner");

    for (int i = 0; i < 6; i++) send_bit(i[0] ? 1'b1 : 1'b0);
    sweep("R4 order after partial load");
    chk("R7 loaded low after 6 bits", loaded, 0);

    do_reset();
    for (int i = 0; i < 383; i++) send_bit(1'($urandom));
    chk("R7 loaded low after 383 bits", loaded, 0);
    send_bit(1'($urandom));
    chk("R7 loaded high after 384 bits", loaded, 1);
    sweep("R3 R4 full random table");

    for (int i = 0; i < 200; i++)
      lookup(int'($urandom % 64), 1'($urandom), "R2 R3 random mixed");

    @(negedge clk);
    cal_clk = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cal_dat = ~cal_dat;
    end
    mdl = {mdl[382:0], cal_dat};
    repeat (4) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cal_dat = ~cal_dat;
    end
    cal_clk = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cal_dat = ~cal_dat;
    end
    repeat (4) @(negedge clk);
    sweep("R9 steady cal_clk ignores cal_dat");

    for (int i = 0; i < 6; i++) send_bit(1'($urandom));
    chk("R7 loaded stays high", loaded, 1);
    sweep("R8 shifting after loaded");

    do_reset();
    chk("R7 loaded cleared by reset", loaded, 0);
    lookup(37, 1'b1, "R5 identity after reset");
    lookup(21, 1'b0, "R2 bypass after reset");

    finish_run();
  end
endmodule